// File: doc/BRIEF.md
# Eight-Pin I/O Port with Level and Change Interrupts

This block is one 8-bit slice of a general-purpose I/O port. A small register bus reaches four registers: the output data register, a per-pin interrupt enable mask, a per-pin bypass-select mask and a single global interrupt-mode bit. Each pin input passes through a two-flop synchroniser. The synchronised values feed the data-register read path and the interrupt logic.

Each enabled pin can raise the shared interrupt line in one of two ways, and one global bit picks the way for all pins. In level mode, a pin interrupts while it reads low. In change mode, a pin interrupts while its level differs from a per-pin snapshot. Only a bus read of the data register refreshes that snapshot, so software has to read the port during every service routine to acknowledge a change. A pin's output comes from the data register. It comes instead from an alternate internal data input when software selects bypass for that pin, or when a hardware function-enable input claims the pin.

Top module: `gpio_chg_port`

## Requirements
- R1: While reset is asserted and after it is released, the data register, interrupt enables, bypass selects, mode bit and snapshot latch are all 0, so `irq` is 0 and each of the four registers reads back as 0.
- R2: With the mode bit at 0, pin i requests an interrupt while its synchronised level is 0 and enable bit i is 1.
- R3: With the mode bit at 1, pin i requests an interrupt while its synchronised level differs from snapshot bit i and enable bit i is 1.
- R4: A read at address 0 returns the synchronised pin levels and loads those same levels into the snapshot latch at the clock edge that ends the read. No other bus access changes the snapshot, including a write to address 0.
- R5: A pin whose enable bit is 0 never affects `irq`, whatever its level and in either mode.
- R6: `irq` is the OR of all per-pin requests. It is a level that falls without any clear, once the condition goes away or a data read refreshes the snapshot.
- R7: `pin_out[i]` equals `alt_data[i]` when bypass-select bit i is 1 or `hw_bypass[i]` is 1. Otherwise it equals data register bit i.
- R8: A change on `pin_in` is first seen by `irq` and by the read path after the second rising clock edge.
- R9: Register map: address 0 is the data register (a write sets the output data, a read returns the pins), address 1 holds the interrupt enables, address 2 holds the bypass selects, and address 3 holds the mode bit in bit 0. Bits 7..1 of address 3 read as 0, and a read returns 0 on `bus_rdata` whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while a read is in progress |
| pin_in | input | 8 | Asynchronous pin levels |
| alt_data | input | 8 | Alternate internal output data |
| hw_bypass | input | 8 | Hardware function claims pin for bypass |
| pin_out | output | 8 | Pin output data |
| irq | output | 1 | Combined interrupt request |

## Verification
The sharp case is a data-register read that lands in the same cycle as a pin transition leaving the synchroniser. The snapshot must take the value the read returns, not the value one cycle later. The bench sets up these collisions on purpose: a pin is toggled two edges before a read, and random traffic mixes pin changes with reads. A behavioural model holds a two-deep queue of pin samples and judges both `bus_rdata` and the following `irq` level on every cycle. A snapshot that takes the wrong sample leaves a stale request visible on `irq`.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_IEN  = 2'd1,
    REG_BYP  = 2'd2,
    REG_MODE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_chg_rstsync.sv
module gpio_chg_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_ni = s2_q;
endmodule

// File: rtl/gpio_chg_sync.sv
module gpio_chg_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;
  logic [W-1:0] s1_d, s2_d;

  always_comb begin
    s1_d = d;
    s2_d = s1_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign q = s2_q;

  // R8
  sync_stage_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    s2_q == $past(s1_q));
endmodule

// File: rtl/gpio_chg_regs.sv
module gpio_chg_regs
  import gpio_chg_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pins_s,
  output logic [W-1:0]      dout,
  output logic [W-1:0]      ien,
  output logic [W-1:0]      bsel,
  output logic              mode,
  output logic [W-1:0]      last_rd
);
  logic [W-1:0] dout_q, dout_d;
  logic [W-1:0] ien_q, ien_d;
  logic [W-1:0] bsel_q, bsel_d;
  logic [W-1:0] lat_q, lat_d;
  logic         mode_q, mode_d;
  logic         wr_en, rd_en;
  logic         data_rd;
  reg_addr_e    addr;

  always_comb begin
    addr    = reg_addr_e'(bus_addr);
    wr_en   = bus_sel & bus_wr;
    rd_en   = bus_sel & ~bus_wr;
    data_rd = rd_en & (addr == REG_DATA);
  end

  always_comb begin
    dout_d = dout_q;
    ien_d  = ien_q;
    bsel_d = bsel_q;
    mode_d = mode_q;
    lat_d  = lat_q;
    if (wr_en) begin
      case (addr)
        REG_DATA: dout_d = bus_wdata;
        REG_IEN:  ien_d  = bus_wdata;
        REG_BYP:  bsel_d = bus_wdata;
        REG_MODE: mode_d = bus_wdata[0];
        default:  ;
      endcase
    end
    if (data_rd) begin
      lat_d = pins_s;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      ien_q  <= '0;
      bsel_q <= '0;
      mode_q <= 1'b0;
      lat_q  <= '0;
    end else begin
      dout_q <= dout_d;
      ien_q  <= ien_d;
      bsel_q <= bsel_d;
      mode_q <= mode_d;
      lat_q  <= lat_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (addr)
        REG_DATA: bus_rdata = pins_s;
        REG_IEN:  bus_rdata = ien_q;
        REG_BYP:  bus_rdata = bsel_q;
        REG_MODE: bus_rdata = {{(W-1){1'b0}}, mode_q};
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign dout    = dout_q;
  assign ien     = ien_q;
  assign bsel    = bsel_q;
  assign mode    = mode_q;
  assign last_rd = lat_q;

  // R4
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_sel && !bus_wr && bus_addr == 2'd0) |=> (last_rd == $past(pins_s)));

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(bus_sel && !bus_wr && bus_addr == 2'd0) |=> $stable(last_rd));
endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_s,
  input  logic [W-1:0] last_rd,
  input  logic [W-1:0] ien,
  input  logic         mode,
  output logic         irq
);
  logic [W-1:0] req;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic lvl_hit, chg_hit;
    always_comb begin
      lvl_hit = ~pins_s[i];
      chg_hit = pins_s[i] ^ last_rd[i];
      req[i]  = ien[i] & (mode ? chg_hit : lvl_hit);
    end
  end

  assign irq = |req;

  // R5
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ien == '0) |-> !irq);

  // R2
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!mode && ((ien & ~pins_s) != '0)) |-> irq);

  // R3
  irq_change_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode && ((ien & (pins_s ^ last_rd)) == '0)) |-> !irq);
endmodule

// File: rtl/gpio_chg_outmux.sv
module gpio_chg_outmux #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] dout,
  input  logic [W-1:0] alt_data,
  input  logic [W-1:0] bsel,
  input  logic [W-1:0] hw_bypass,
  output logic [W-1:0] pin_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic use_alt;
    always_comb begin
      use_alt    = bsel[i] | hw_bypass[i];
      pin_out[i] = use_alt ? alt_data[i] : dout[i];
    end
  end

  // R7
  out_direct_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ((bsel | hw_bypass) == '0) |-> (pin_out == dout));

  // R7
  out_bypass_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ((bsel | hw_bypass) == '1) |-> (pin_out == alt_data));
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_chg_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  input  logic [W-1:0]      alt_data,
  input  logic [W-1:0]      hw_bypass,
  output logic [W-1:0]      pin_out,
  output logic              irq
);
  logic         rst_ni;
  logic [W-1:0] pins_s;
  logic [W-1:0] dout, ien, bsel, last_rd;
  logic         mode;

  gpio_chg_rstsync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  gpio_chg_sync #(.W(W)) u_sync (
    .clk    (clk),
    .rst_ni (rst_ni),
    .d      (pin_in),
    .q      (pins_s)
  );

  gpio_chg_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pins_s    (pins_s),
    .dout      (dout),
    .ien       (ien),
    .bsel      (bsel),
    .mode      (mode),
    .last_rd   (last_rd)
  );

  gpio_chg_irq #(.W(W)) u_irq (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .pins_s  (pins_s),
    .last_rd (last_rd),
    .ien     (ien),
    .mode    (mode),
    .irq     (irq)
  );

  gpio_chg_outmux #(.W(W)) u_out (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .dout      (dout),
    .alt_data  (alt_data),
    .bsel      (bsel),
    .hw_bypass (hw_bypass),
    .pin_out   (pin_out)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_ni |-> (!irq && bus_rdata == '0));
endmodule

// File: tb/gpio_chg_port_tb.sv
module gpio_chg_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = 8'hA5;
  logic [7:0] alt_data = 8'h00;
  logic [7:0] hw_bypass = 8'h00;
  logic [7:0] pin_out;
  logic       irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_chg_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .alt_data(alt_data), .hw_bypass(hw_bypass),
    .pin_out(pin_out), .irq(irq)
  );

  // behavioural reference model
  logic [7:0] q[$];
  int         rcnt = 0;
  logic [7:0] m_dout = 0, m_ien = 0, m_bsel = 0, m_lat = 0, m_syn;
  logic       m_mode = 0;

  function automatic logic [7:0] synced();
    return (q.size() == 2) ? q[0] : 8'h00;
  endfunction

  function automatic logic m_irq();
    logic [7:0] s = synced();
    for (int i = 0; i < 8; i++)
      if (m_ien[i] && (m_mode ? (s[i] != m_lat[i]) : !s[i])) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] m_rdata();
    if (!bus_sel || bus_wr) return 8'h00;
    case (bus_addr)
      2'd0: return synced();
      2'd1: return m_ien;
      2'd2: return m_bsel;
      default: return {7'b0, m_mode};
    endcase
  endfunction

  function automatic logic [7:0] m_pout();
    logic [7:0] o;
    for (int i = 0; i < 8; i++)
      o[i] = (m_bsel[i] || hw_bypass[i]) ? alt_data[i] : m_dout[i];
    return o;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || rcnt < 2) begin
      if (!rst_n) rcnt = 0; else rcnt = rcnt + 1;
      m_dout = 0; m_ien = 0; m_bsel = 0; m_mode = 0; m_lat = 0;
      q.delete();
    end else begin
      m_syn = synced();
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          2'd0: m_dout = bus_wdata;
          2'd1: m_ien  = bus_wdata;
          2'd2: m_bsel = bus_wdata;
          default: m_mode = bus_wdata[0];
        endcase
      end else if (bus_sel && bus_addr == 2'd0) begin
        m_lat = m_syn;
      end
      q.push_back(pin_in);
      if (q.size() > 2) void'(q.pop_front());
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && rcnt >= 2 && !done) begin
      chk("R2/R3/R5/R6 irq", {7'b0, irq}, {7'b0, m_irq()});
      chk("R7 pin_out", pin_out, m_pout());
      if (bus_sel && !bus_wr) chk("R4/R9 rdata", bus_rdata, m_rdata());
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); #1;
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #3 d = bus_rdata;
    @(negedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic set_pins(logic [7:0] p);
    @(negedge clk); #1;
    pin_in = p;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    idle(3);
    #1 chk("R1 irq in reset", {7'b0, irq}, 8'h00);
    rst_n = 1;
    idle(4);
    // R1 / R9: all registers clear
    rd(2'd1, r); chk("R1 ien", r, 8'h00);
    rd(2'd2, r); chk("R1 bsel", r, 8'h00);
    rd(2'd3, r); chk("R1 mode", r, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd(2'd0, r); chk("R9 data read pins", r, 8'hA5);

    // R2 level mode
    wr(2'd1, 8'hFF);
    idle(1);
    chk("R2 low pins raise irq", {7'b0, irq}, 8'h01);
    set_pins(8'hFF); idle(2);
    chk("R6 irq falls with no clear", {7'b0, irq}, 8'h00);

    // R8 two-edge latency
    set_pins(8'hFE);
    @(negedge clk); chk("R8 after one edge", {7'b0, irq}, 8'h00);
    @(negedge clk); chk("R8 after two edges", {7'b0, irq}, 8'h01);

    // R5 enable mask
    wr(2'd1, 8'h01);
    set_pins(8'hFD); idle(3);
    chk("R5 masked low pin", {7'b0, irq}, 8'h00);
    set_pins(8'hFC); idle(3);
    chk("R5 enabled pin low", {7'b0, irq}, 8'h01);

    // R3 change mode, latch holds 0 from last read? latch = A5 here
    wr(2'd1, 8'hFF);
    wr(2'd3, 8'h01);
    rd(2'd3, r); chk("R9 mode bit", r, 8'h01);
    set_pins(8'h5A); idle(3);
    rd(2'd0, r); chk("R4 read returns pins", r, 8'h5A);
    idle(1);
    chk("R3 read acknowledges change", {7'b0, irq}, 8'h00);
    wr(2'd0, 8'h00); idle(1);
    chk("R4 data write leaves latch", {7'b0, irq}, 8'h00);
    set_pins(8'h5B); idle(3);
    chk("R3 change raises irq", {7'b0, irq}, 8'h01);
    set_pins(8'h5A); idle(3);
    chk("R6 change back drops irq", {7'b0, irq}, 8'h00);

    // collision: pin change reaching the synchroniser on the read edge
    set_pins(8'h0F);
    rd(2'd0, r);
    chk("R4 collision read value", r, 8'h5A);
    idle(2);
    chk("R4 stale change visible", {7'b0, irq}, 8'h01);
    rd(2'd0, r); idle(1);
    chk("R4 second read clears", {7'b0, irq}, 8'h00);

    // R7 bypass
    wr(2'd0, 8'h3C);
    alt_data = 8'hC3; hw_bypass = 8'h30;
    wr(2'd2, 8'h0F);
    idle(1);
    chk("R7 mixed bypass", pin_out, 8'h03);
    rd(2'd2, r); chk("R9 bsel readback", r, 8'h0F);

    // random traffic against the model
    for (int k = 0; k < 400; k++) begin
      @(negedge clk); #1;
      if ($urandom_range(0, 3) == 0) pin_in = 8'($urandom);
      alt_data = 8'($urandom);
      hw_bypass = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      bus_sel = ($urandom_range(0, 2) == 0);
      bus_wr = $urandom_range(0, 1);
      bus_addr = 2'($urandom);
      bus_wdata = 8'($urandom);
    end
    @(negedge clk); #1 bus_sel = 0;
    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule